// File: doc/BRIEF.md
# Transmit Checksum Offload Inserter

This block sits in a transmit path in front of the MAC. For each frame it first takes a five-word control header on a 32-bit sideband stream, then takes the frame bytes on a byte stream and stores the whole frame in an internal buffer. While the bytes arrive it adds them into a running 16-bit ones'-complement sum, beginning at a start offset that the header gives. The header also supplies a seed and a write offset. After the last byte arrives, the block decides whether the frame may be sent. If checksum insertion was asked for, it writes the finished checksum back into the buffered frame, big-endian, at the write offset. It then sends the frame out on a valid/ready stream.

A 32-bit transmit control register sets which frames are sent:
- Bit 28 enables transmission.
- Bit 30 allows jumbo lengths.
- Bit 27 allows VLAN-tagged lengths.

A write that has bit 31 set restores the register's default value. The block keeps a 64-bit total of transmitted bytes and pulses a completion flag for each frame it sends.

The control state machine has six states:
- HDR waits for a valid header. A good header moves it to LOAD.
- LOAD stores bytes. The last byte moves it to JUDGE.
- JUDGE drops the frame and returns to HDR, or moves to PATCH_HI when insertion is enabled, or to SEND when it is not.
- PATCH_HI writes the high byte and always moves to PATCH_LO.
- PATCH_LO writes the low byte and always moves to SEND.
- SEND emits the frame. The handshake on the last byte returns it to HDR.

Top module: `tx_csum_inserter`

## Requirements
- R1: A header is five control words, and the fifth carries ctl_last. Headers are accepted only while the block waits for one (ctl_ready high). If ctl_last comes on an earlier word, or the fifth word lacks it, hdr_err pulses for one cycle in the cycle after that word is accepted. The block then ignores control words up to and including the next ctl_last, and keeps waiting for a valid header.
- R2: Header word 0 bit 0 enables insertion. Word 1 bits 31:16 give the start offset and bits 15:0 give the write offset. Word 2 bits 15:0 give the seed. All other header bits are ignored.
- R3: The checksum is computed as follows. Frame bytes from the start offset to the end are taken as big-endian 16-bit words, and an odd final byte is padded with a zero low byte. The seed is added, the sum is folded to 16 bits with end-around carries, and the result is complemented. If the start offset is at or beyond the frame length, the result is the complement of the seed.
- R4: With insertion enabled, the checksum's high byte replaces the frame byte at the write offset and its low byte replaces the byte at write offset + 1. A position at or beyond the frame length is not written. With insertion disabled, the frame is sent unchanged.
- R5: No output byte appears before the last input byte has been accepted, and in_ready is low while a frame is being sent. While out_valid is high and out_ready is low, out_valid, out_data and out_last hold their values.
- R6: If transmit control bit 28 is clear when a frame ends, the frame is taken in full and dropped. Nothing is sent, tx_done does not pulse and byte_total does not change.
- R7: If bits 30 and 27 are both clear, frames of 1519 to 1522 bytes are dropped, while frames of 1518 and 1523 bytes are sent. Setting either bit lets these lengths through.
- R8: The transmit control register resets to 0x5800_0000. A write with bit 31 set loads 0x5800_0000, and any other write loads the written value. txc_q shows the current value from the cycle after the write.
- R9: In the cycle after the handshake on a sent frame's last byte, tx_done is high for one cycle and byte_total has grown by that frame's length. At no other time does byte_total change.
- R10: A frame longer than DEPTH bytes is taken in full and dropped. A frame of exactly DEPTH bytes is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_valid | input | 1 | Header word valid |
| ctl_data | input | 32 | Header word |
| ctl_last | input | 1 | Marks the last header word |
| ctl_ready | output | 1 | Header word accepted when high with ctl_valid |
| hdr_err | output | 1 | One-cycle pulse for a header of the wrong length |
| txc_we | input | 1 | Write strobe for the transmit control register |
| txc_wdata | input | 32 | Value written to the transmit control register |
| txc_q | output | 32 | Current transmit control register |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last frame byte |
| in_ready | output | 1 | Frame byte accepted when high with in_valid |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Marks the last output byte |
| out_ready | input | 1 | Downstream accepts the output byte |
| tx_done | output | 1 | One-cycle pulse after a frame has been sent |
| byte_total | output | 64 | Running total of bytes sent |

## Verification
The assertions check the following on every cycle:
- The output holds its value under backpressure.
- A register write with bit 31 set restores the default.
- byte_total changes only together with tx_done, and then it grows.
- The accumulator sum stays still when there is no clear and no add.
- Disabled and oversized frames go straight back to header wait.
- The header parser never reports success and error together.

Only the bench's scenarios can show the following:
- That the checksum has the right value and lands at the right positions.
- The truncation of a write offset that lies past the frame end.
- The exact length window that triggers a drop.
- That a malformed header is followed by a good frame, which is then handled correctly.

// File: rtl/csum_pkg.sv
package csum_pkg;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_LOAD,
        ST_JUDGE,
        ST_PATCH_HI,
        ST_PATCH_LO,
        ST_SEND
    } phase_t;

    typedef struct packed {
        logic        ins_en;
        logic [15:0] start_off;
        logic [15:0] wr_off;
        logic [15:0] seed;
    } csum_hdr_t;

    localparam int          HDR_WORDS     = 5;
    localparam logic [31:0] TXCTL_DEFAULT = 32'h5800_0000;
    localparam int          BIT_VLAN      = 27;
    localparam int          BIT_TXEN      = 28;
    localparam int          BIT_JUMBO     = 30;
    localparam int          BIT_RESTORE   = 31;
    localparam int          TAG_LEN_LO    = 1519;
    localparam int          TAG_LEN_HI    = 1522;

    // two end-around folds always reach 16 bits, then complement
    function automatic logic [15:0] fold_cpl(input logic [31:0] s);
        logic [16:0] a;
        logic [16:0] b;
        a = {1'b0, s[15:0]} + {1'b0, s[31:16]};
        b = {1'b0, a[15:0]} + {16'd0, a[16]};
        return ~b[15:0];
    endfunction

endpackage

// File: rtl/csum_hdr_rx.sv
module csum_hdr_rx
    import csum_pkg::*;
#(
    parameter int WORDS = HDR_WORDS
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm,
    input  logic        w_valid,
    input  logic [31:0] w_data,
    input  logic        w_last,
    output logic        w_ready,
    output logic        hdr_ok,
    output logic        hdr_err,
    output csum_hdr_t   hdr
);
    localparam int CW = $clog2(WORDS + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(WORDS - 1);

    typedef enum logic {PS_COLLECT, PS_FLUSH} pstate_t;

    pstate_t       ps, ps_nx;
    logic [CW-1:0] idx;
    logic          take;

    assign w_ready = arm && !hdr_ok;
    assign take    = w_valid && w_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) ps <= PS_COLLECT;
        else        ps <= ps_nx;
    end

    always_comb begin
        ps_nx = ps;
        unique case (ps)
            PS_COLLECT: if (take && !w_last && idx == LAST_IDX) ps_nx = PS_FLUSH;
            PS_FLUSH:   if (take && w_last)                     ps_nx = PS_COLLECT;
            default:    ps_nx = PS_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            hdr_ok  <= 1'b0;
            hdr_err <= 1'b0;
            hdr     <= '0;
        end else begin
            hdr_ok  <= 1'b0;
            hdr_err <= 1'b0;
            if (take && ps == PS_COLLECT) begin
                if (idx == CW'(0)) hdr.ins_en <= w_data[0];
                if (idx == CW'(1)) begin
                    hdr.start_off <= w_data[31:16];
                    hdr.wr_off    <= w_data[15:0];
                end
                if (idx == CW'(2)) hdr.seed <= w_data[15:0];
                if (w_last) begin
                    idx <= '0;
                    if (idx == LAST_IDX) hdr_ok  <= 1'b1;
                    else                 hdr_err <= 1'b1;
                end else if (idx == LAST_IDX) begin
                    idx     <= '0;
                    hdr_err <= 1'b1;
                end else begin
                    idx <= idx + CW'(1);
                end
            end
        end
    end

    // R1: a header ends either good or bad, never both
    a_r1_ok_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_ok && hdr_err));

    // R1: success is only reported for a word that carried the last marker
    a_r1_ok_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !w_last) |=> !hdr_ok);

endmodule

// File: rtl/csum_sum.sv
module csum_sum
    import csum_pkg::*;
#(
    parameter int LW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          add,
    input  logic [LW-1:0] pos,
    input  logic [7:0]    byte_in,
    input  logic [15:0]   start_off,
    input  logic [15:0]   seed,
    output logic [15:0]   csum
);
    logic [31:0] acc;
    logic [31:0] pos32;
    logic [31:0] start32;
    logic [31:0] rel;
    logic        in_range;
    logic [31:0] term;

    assign pos32    = 32'(pos);
    assign start32  = 32'(start_off);
    assign rel      = pos32 - start32;
    assign in_range = pos32 >= start32;
    assign term     = rel[0] ? {24'd0, byte_in} : {16'd0, byte_in, 8'd0};

    always_ff @(posedge clk) begin
        if (!rst_n || clear)        acc <= '0;
        else if (add && in_range)   acc <= acc + term;
    end

    assign csum = fold_cpl(acc + {16'd0, seed});

    // R3: the running sum moves only while bytes are being added
    a_r3_acc_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !add) |=> $stable(acc));

endmodule

// File: rtl/csum_fbuf.sv
module csum_fbuf #(
    parameter int DEPTH = 4096,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/tx_csum_inserter.sv
module tx_csum_inserter
    import csum_pkg::*;
#(
    parameter int DEPTH = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_valid,
    input  logic [31:0] ctl_data,
    input  logic        ctl_last,
    output logic        ctl_ready,
    output logic        hdr_err,
    input  logic        txc_we,
    input  logic [31:0] txc_wdata,
    output logic [31:0] txc_q,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        in_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    input  logic        out_ready,
    output logic        tx_done,
    output logic [63:0] byte_total
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] LEN_CAP = LW'(DEPTH);

    phase_t        st, st_nx;
    csum_hdr_t     hdr;
    logic          hdr_ok;
    logic          arm;
    logic [LW-1:0] len;
    logic [LW-1:0] rd_ptr;
    logic          ovf;
    logic [15:0]   csum;
    logic          buf_we;
    logic [AW-1:0] buf_wa;
    logic [7:0]    buf_wd;
    logic [7:0]    buf_rd;
    logic          in_take;
    logic          out_take;
    logic          room;
    logic          len_bad;
    logic          keep;
    logic [31:0]   len32;
    logic [31:0]   wo32;

    assign in_take  = in_valid && in_ready;
    assign out_take = out_valid && out_ready;
    assign room     = len < LEN_CAP;
    assign len32    = 32'(len);
    assign wo32     = 32'(hdr.wr_off);
    assign len_bad  = !txc_q[BIT_JUMBO] && !txc_q[BIT_VLAN] &&
                      len32 >= 32'(TAG_LEN_LO) && len32 <= 32'(TAG_LEN_HI);
    assign keep     = txc_q[BIT_TXEN] && !ovf && !len_bad;

    csum_hdr_rx #(.WORDS(HDR_WORDS)) u_hdr (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .w_valid (ctl_valid),
        .w_data  (ctl_data),
        .w_last  (ctl_last),
        .w_ready (ctl_ready),
        .hdr_ok  (hdr_ok),
        .hdr_err (hdr_err),
        .hdr     (hdr)
    );

    csum_sum #(.LW(LW)) u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (hdr_ok),
        .add       (in_take && room),
        .pos       (len),
        .byte_in   (in_data),
        .start_off (hdr.start_off),
        .seed      (hdr.seed),
        .csum      (csum)
    );

    csum_fbuf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_wa),
        .wdata (buf_wd),
        .raddr (rd_ptr[AW-1:0]),
        .rdata (buf_rd)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_HDR;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_HDR:      if (hdr_ok) st_nx = ST_LOAD;
            ST_LOAD:     if (in_take && in_last) st_nx = ST_JUDGE;
            ST_JUDGE: begin
                if (!keep)            st_nx = ST_HDR;
                else if (hdr.ins_en)  st_nx = ST_PATCH_HI;
                else                  st_nx = ST_SEND;
            end
            ST_PATCH_HI: st_nx = ST_PATCH_LO;
            ST_PATCH_LO: st_nx = ST_SEND;
            ST_SEND:     if (out_take && out_last) st_nx = ST_HDR;
            default:     st_nx = ST_HDR;
        endcase
    end

    // outputs and buffer write port
    always_comb begin
        arm       = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        out_data  = buf_rd;
        buf_we    = 1'b0;
        buf_wa    = len[AW-1:0];
        buf_wd    = in_data;
        unique case (st)
            ST_HDR:  arm = 1'b1;
            ST_LOAD: begin
                in_ready = 1'b1;
                buf_we   = in_valid && room;
            end
            ST_JUDGE: ;
            ST_PATCH_HI: begin
                buf_we = wo32 < len32;
                buf_wa = hdr.wr_off[AW-1:0];
                buf_wd = csum[15:8];
            end
            ST_PATCH_LO: begin
                buf_we = (wo32 + 32'd1) < len32;
                buf_wa = AW'(wo32 + 32'd1);
                buf_wd = csum[7:0];
            end
            ST_SEND: begin
                out_valid = 1'b1;
                out_last  = rd_ptr == len - LW'(1);
            end
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len        <= '0;
            ovf        <= 1'b0;
            rd_ptr     <= '0;
            tx_done    <= 1'b0;
            byte_total <= '0;
            txc_q      <= TXCTL_DEFAULT;
        end else begin
            tx_done <= 1'b0;
            if (txc_we) txc_q <= txc_wdata[BIT_RESTORE] ? TXCTL_DEFAULT : txc_wdata;
            if (st == ST_HDR && hdr_ok) begin
                len <= '0;
                ovf <= 1'b0;
            end
            if (in_take) begin
                if (room) len <= len + LW'(1);
                else      ovf <= 1'b1;
            end
            if (st == ST_JUDGE) rd_ptr <= '0;
            if (out_take) begin
                rd_ptr <= rd_ptr + LW'(1);
                if (out_last) begin
                    tx_done    <= 1'b1;
                    byte_total <= byte_total + 64'(len);
                end
            end
        end
    end

    // R5: the output is held while the sink stalls
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R8: a restore write brings back the default
    a_r8_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (txc_we && txc_wdata[BIT_RESTORE]) |=> (txc_q == TXCTL_DEFAULT));

    // R9: total moves only with the completion pulse, and then it grows
    a_r9_total_still: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_done |-> $stable(byte_total));
    a_r9_total_grows: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (byte_total > $past(byte_total)));

    // R6: a disabled transmitter sends nothing
    a_r6_disabled_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_JUDGE && !txc_q[BIT_TXEN]) |=> (st == ST_HDR));

    // R10: an overrun frame is dropped
    a_r10_ovf_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_JUDGE && ovf) |=> (st == ST_HDR && !out_valid));

endmodule

// File: tb/sim_tx_csum_inserter.sv
`timescale 1ns/1ps
module sim_tx_csum_inserter;
    localparam int DEPTH = 4096;
    typedef byte unsigned bytes_t[];

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_valid = 1'b0;
    logic [31:0] ctl_data = '0;
    logic        ctl_last = 1'b0;
    logic        ctl_ready;
    logic        hdr_err;
    logic        txc_we = 1'b0;
    logic [31:0] txc_wdata = '0;
    logic [31:0] txc_q;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_last;
    logic        out_ready = 1'b1;
    logic        tx_done;
    logic [63:0] byte_total;

    always #2.5 clk = ~clk;

    tx_csum_inserter #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ctl_valid(ctl_valid), .ctl_data(ctl_data), .ctl_last(ctl_last),
        .ctl_ready(ctl_ready), .hdr_err(hdr_err),
        .txc_we(txc_we), .txc_wdata(txc_wdata), .txc_q(txc_q),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
        .tx_done(tx_done), .byte_total(byte_total)
    );

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    int    err_seen = 0;
    string cur_req = "R1";
    bit    bp_on = 1'b0;
    bit    running = 1'b0;

    // reference model state
    byte unsigned exp_q[$];
    bit           exp_last_q[$];
    int           exp_len_q[$];
    logic [31:0]  mdl_txc = 32'h5800_0000;
    logic [63:0]  mdl_total = '0;
    bit           exp_done = 1'b0;
    bit           exp_err = 1'b0;
    int           m_idx = 0;
    bit           m_skip = 1'b0;
    bit           prev_ov = 1'b0;
    bit           prev_or = 1'b0;
    logic [7:0]   prev_od = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (running) begin
            chk(txc_q == mdl_txc, "R8", "txc_q", txc_q, mdl_txc);
            chk(byte_total == mdl_total, "R9", "byte_total", byte_total, mdl_total);
            chk(tx_done == exp_done, "R9", "tx_done", tx_done, exp_done);
            chk(hdr_err == exp_err, "R1", "hdr_err", hdr_err, exp_err);
            if (hdr_err) err_seen++;
            chk(!(out_valid && in_ready), "R5", "out_valid during load", out_valid, 0);
            if (prev_ov && !prev_or)
                chk(out_valid && out_data == prev_od, "R5", "held byte", out_data, prev_od);
            exp_done = 1'b0;
            exp_err  = 1'b0;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected output byte", out_data, 0);
                end else begin
                    chk(out_data == exp_q[0], cur_req, "out_data", out_data, exp_q[0]);
                    chk(out_last == exp_last_q[0], cur_req, "out_last", out_last, exp_last_q[0]);
                    if (exp_last_q[0]) begin
                        exp_done  = 1'b1;
                        mdl_total = mdl_total + 64'(exp_len_q.pop_front());
                    end
                    void'(exp_q.pop_front());
                    void'(exp_last_q.pop_front());
                end
            end
            if (ctl_valid && ctl_ready) begin
                if (m_skip) begin
                    if (ctl_last) m_skip = 1'b0;
                end else if (ctl_last) begin
                    exp_err = (m_idx != 4);
                    m_idx = 0;
                end else if (m_idx == 4) begin
                    exp_err = 1'b1;
                    m_skip = 1'b1;
                    m_idx = 0;
                end else begin
                    m_idx++;
                end
            end
            if (txc_we) mdl_txc = txc_wdata[31] ? 32'h5800_0000 : txc_wdata;
            prev_ov = out_valid;
            prev_or = out_ready;
            prev_od = out_data;
        end
    end

    always @(posedge clk) begin
        #1;
        out_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    function automatic bytes_t make_frame(input int n, input int k);
        bytes_t f = new[n];
        for (int i = 0; i < n; i++) f[i] = 8'((i * 7 + k * 13 + (i >> 3)) & 255);
        return f;
    endfunction

    // R2 R3 R4 R6 R7 R10: expected output computed from the requirements
    task automatic expect_frame(input bytes_t f, input bit en, input int st, input int wo,
                                input int seed);
        int n = f.size();
        bytes_t g = new[n](f);
        bit keep;
        longint s;
        logic [15:0] c;
        keep = mdl_txc[28] && n <= DEPTH &&
               !(!mdl_txc[30] && !mdl_txc[27] && n >= 1519 && n <= 1522);
        if (!keep) return;
        if (en) begin
            s = seed;
            for (int i = st; i < n; i++)
                s += (((i - st) % 2) == 0) ? (longint'(f[i]) << 8) : longint'(f[i]);
            while ((s >> 16) != 0) s = (s & 64'hffff) + (s >> 16);
            c = ~s[15:0];
            if (wo < n)     g[wo] = c[15:8];
            if (wo + 1 < n) g[wo + 1] = c[7:0];
        end
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(g[i]);
            exp_last_q.push_back(i == n - 1);
        end
        exp_len_q.push_back(n);
    endtask

    task automatic send_hdr(input int nw, input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2);
        bit ok;
        for (int i = 0; i < nw; i++) begin
            ctl_valid = 1'b1;
            ctl_data  = (i == 0) ? w0 : (i == 1) ? w1 : (i == 2) ? w2 : 32'hA5A5_0000 + i;
            ctl_last  = (i == nw - 1);
            do begin
                @(negedge clk);
                ok = ctl_ready;
                @(posedge clk);
                #1;
            end while (!ok);
        end
        ctl_valid = 1'b0;
        ctl_last  = 1'b0;
    endtask

    task automatic send_bytes(input bytes_t f);
        bit ok;
        for (int i = 0; i < f.size(); i++) begin
            in_valid = 1'b1;
            in_data  = f[i];
            in_last  = (i == f.size() - 1);
            do begin
                @(negedge clk);
                ok = in_ready;
                @(posedge clk);
                #1;
            end while (!ok);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while ((exp_q.size() != 0 || !ctl_ready) && n < 20000) begin
            @(posedge clk);
            #1;
            n++;
        end
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic run_frame(input bytes_t f, input bit en, input int st, input int wo,
                             input int seed);
        expect_frame(f, en, st, wo, seed);
        send_hdr(5, {31'h2A00_0000, en}, {16'(st), 16'(wo)}, {16'hBEEF, 16'(seed)});
        send_bytes(f);
        drain();
    endtask

    task automatic cfg_write(input logic [31:0] v);
        txc_we    = 1'b1;
        txc_wdata = v;
        @(posedge clk);
        #1;
        txc_we = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(txc_q == 32'h5800_0000, "R8", "reset txc_q", txc_q, 32'h5800_0000);
        chk(byte_total == 0, "R9", "reset byte_total", byte_total, 0);
        chk(!out_valid && !tx_done, "R5", "reset outputs idle", out_valid, 0);
        chk(ctl_ready && !in_ready, "R1", "reset waits for header", ctl_ready, 1);
        running = 1'b1;
        @(posedge clk);
        #1;

        cur_req = "R3";
        run_frame(make_frame(64, 1), 1'b1, 14, 24, 16'h1234);
        cur_req = "R2";
        run_frame(make_frame(60, 2), 1'b1, 0, 0, 16'hFFFF);
        cur_req = "R5";
        bp_on = 1'b1;
        run_frame(make_frame(77, 3), 1'b1, 15, 75, 16'h0001);
        cur_req = "R4";
        run_frame(make_frame(50, 4), 1'b0, 10, 20, 16'h5555);
        run_frame(make_frame(41, 5), 1'b1, 3, 40, 16'h00AA);
        run_frame(make_frame(41, 6), 1'b1, 3, 300, 16'h00AA);
        cur_req = "R3";
        run_frame(make_frame(30, 7), 1'b1, 100, 4, 16'h4321);
        bp_on = 1'b0;

        cur_req = "R1";
        err_seen = 0;
        send_hdr(3, 32'h1, 32'h0, 32'h0);
        send_hdr(6, 32'h1, 32'h0, 32'h0);
        repeat (3) @(posedge clk);
        #1;
        chk(err_seen == 2, "R1", "header error pulses", err_seen, 2);
        run_frame(make_frame(33, 8), 1'b1, 2, 6, 16'h0F0F);

        begin
            logic [63:0] t0;
            cur_req = "R6";
            cfg_write(32'h4800_0000);
            t0 = byte_total;
            run_frame(make_frame(40, 9), 1'b1, 0, 0, 0);
            chk(byte_total == t0, "R6", "total after disabled frame", byte_total, t0);

            cur_req = "R7";
            cfg_write(32'h1000_0000);
            run_frame(make_frame(1518, 10), 1'b0, 0, 0, 0);
            t0 = byte_total;
            run_frame(make_frame(1519, 11), 1'b0, 0, 0, 0);
            run_frame(make_frame(1522, 12), 1'b0, 0, 0, 0);
            chk(byte_total == t0, "R7", "total after tagged-length drops", byte_total, t0);
            run_frame(make_frame(1523, 13), 1'b0, 0, 0, 0);
            cfg_write(32'h1800_0000);
            t0 = byte_total;
            run_frame(make_frame(1520, 14), 1'b1, 14, 30, 16'h0002);
            chk(byte_total == t0 + 1520, "R7", "vlan length passes", byte_total, t0 + 1520);

            cur_req = "R8";
            cfg_write(32'h8000_0000);
            cfg_write(32'h0000_1234);
            cfg_write(32'hFFFF_FFFF);
            chk(txc_q == 32'h5800_0000, "R8", "restore write", txc_q, 32'h5800_0000);

            cur_req = "R10";
            t0 = byte_total;
            run_frame(make_frame(DEPTH + 1, 15), 1'b1, 0, 0, 0);
            chk(byte_total == t0, "R10", "overlong frame dropped", byte_total, t0);
            run_frame(make_frame(DEPTH, 16), 1'b1, 20, DEPTH - 2, 16'h7777);
            chk(byte_total == t0 + DEPTH, "R10", "full-depth frame sent", byte_total,
                t0 + DEPTH);
        end
        chk(exp_q.size() == 0, "R9", "all expected bytes emitted", exp_q.size(), 0);

        running = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 190000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule